// File: doc/BRIEF.md
# Multiplexed-Bus Scratchpad Slave

This block is a memory-mapped slave on a 16-bit bus that carries address and data on the same wires. A 3-bit phase code from the processor names the bus cycle. Each clock cycle carries one phase. The slave tracks all eight phase kinds. It keeps a latched access address and decodes it against a parameterised window. It answers reads from an internal 256-word scratchpad RAM, and it commits writes into that RAM. It also handles the interrupt cycles: it captures the stack pointer that is offered on acknowledge, and it supplies a fixed service address when the vector is requested.

The sixteen highest words of the window do not map to the RAM. Reads and writes there are sent to a narrow peripheral port. That port carries a 4-bit offset, the write data, a single-cycle write pulse, a read enable and a return data word. The shared bus is presented as a separate input, an output word and an output enable. A pad cell outside this block merges them into the tri-state wires.

Top module: `mbus_slave`

## Requirements
- R1: After reset the latched address is 0x0000, the write holding word is 0x0000, and both the bus enable and the peripheral write pulse are low.
- R2: A word on the bus during the address phase (code 4) becomes the latched address at the end of that cycle.
- R3: In the read phase (code 3), the slave enables the bus and drives the addressed word only when the latched address lies in the window `BASE_ADDR .. BASE_ADDR+DEPTH-1`. Outside the window it keeps the bus released.
- R4: The bus enable stays low in the idle (0), address (4), write (5), write-strobe (6) and interrupt-acknowledge (7) phases. The idle phase changes no state.
- R5: The word on the bus during the write phase (5) is held. The write-strobe phase (6) commits it to the RAM at the latched address when that address is in the RAM part of the window. Later reads return it.
- R6: In the next-address phase (code 1), a selected slave drives its addressed word and latches that same word as the new address. An unselected slave keeps the bus released and latches the word seen on the bus.
- R7: In the interrupt-acknowledge phase (code 7), the stack-pointer word on the bus becomes the latched address, so the push write that follows lands there.
- R8: In the interrupt-vector phase (code 2), the slave always enables the bus and drives the parameter `IRQ_VECTOR`.
- R9: When the latched address has bits [AW-1:4] all ones inside the window, read and next-address phases raise the peripheral read enable. They return the peripheral data word, and the peripheral offset equals address bits [3:0].
- R10: A write-strobe phase to the peripheral sub-window raises the write pulse for exactly that cycle and presents the held write word. RAM writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 3 | Bus phase code of the current cycle |
| db_in | input | 16 | Word currently on the shared bus |
| db_out | output | 16 | Word this slave drives when enabled |
| db_oe | output | 1 | Bus drive enable |
| per_addr | output | 4 | Peripheral register offset |
| per_wdata | output | 16 | Peripheral write word |
| per_we | output | 1 | Peripheral write pulse |
| per_rd_en | output | 1 | Peripheral read enable |
| per_rdata | input | 16 | Peripheral read word |

## Verification
The bench uses a window base of 0x0100 with depth 256. The upper address byte therefore has to match a nonzero value, and the peripheral sub-window falls at 0x01F0..0x01FF, where both the RAM and the port paths can be reached from ordinary bus addresses. The vector 0x1004 is distinct from any RAM pattern, so a misrouted drive in the vector phase shows up. The random phase stream also places in-window words into the next-address phase, which makes pointer-chasing chains through the scratchpad occur.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_NEXTA = 3'd1,
        PH_IVEC  = 3'd2,
        PH_RDATA = 3'd3,
        PH_ADDR  = 3'd4,
        PH_WR    = 3'd5,
        PH_WRSTB = 3'd6,
        PH_IACK  = 3'd7
    } bus_phase_e;

    typedef struct packed {
        logic hit;
        logic per;
        logic ram;
    } win_t;

    function automatic logic is_read_phase(bus_phase_e p);
        return (p == PH_RDATA) || (p == PH_NEXTA);
    endfunction

    function automatic logic loads_addr_from_bus(bus_phase_e p);
        return (p == PH_ADDR) || (p == PH_IACK);
    endfunction

endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
#(
    parameter int          AW        = 8,
    parameter logic [15:0] BASE_ADDR = 16'h0100
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_phase_e  ph,
    input  logic [15:0] db_in,
    input  logic [15:0] own_word,
    output logic [15:0] addr_q,
    output logic [15:0] wdata_q,
    output win_t        win
);
    always_comb begin
        win.hit = (addr_q[15:AW] == BASE_ADDR[15:AW]);
        win.per = win.hit && (&addr_q[AW-1:4]);
        win.ram = win.hit && !win.per;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= 16'h0000;
            wdata_q <= 16'h0000;
        end else begin
            if (loads_addr_from_bus(ph))
                addr_q <= db_in;
            else if (ph == PH_NEXTA)
                addr_q <= win.hit ? own_word : db_in;
            if (ph == PH_WR)
                wdata_q <= db_in;
        end
    end

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ADDR) |=> (addr_q == $past(db_in)));

    // R7
    iack_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IACK) |=> (addr_q == $past(db_in)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |=> ($stable(addr_q) && $stable(wdata_q)));
endmodule

// File: rtl/mbus_scratch.sv
module mbus_scratch #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter logic [15:0] IRQ_VECTOR = 16'h1004
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_phase_e  ph,
    input  win_t        win,
    input  logic [15:0] ram_rdata,
    input  logic [15:0] per_rdata,
    output logic [15:0] word,
    output logic [15:0] dout,
    output logic        oe,
    output logic        per_rd_en,
    output logic        per_we,
    output logic        ram_we
);
    always_comb begin
        word      = win.per ? per_rdata : ram_rdata;
        per_rd_en = is_read_phase(ph) && win.per;
        per_we    = (ph == PH_WRSTB) && win.per;
        ram_we    = (ph == PH_WRSTB) && win.ram;
        oe        = 1'b0;
        dout      = 16'h0000;
        unique case (ph)
            PH_IVEC: begin
                oe   = 1'b1;
                dout = IRQ_VECTOR;
            end
            PH_RDATA, PH_NEXTA: begin
                oe   = win.hit;
                dout = win.hit ? word : 16'h0000;
            end
            default: begin
                oe   = 1'b0;
                dout = 16'h0000;
            end
        endcase
    end

    // R10
    we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        per_we |-> (!ram_we && !per_rd_en && !oe));
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR  = 16'h0100,
    parameter int          DEPTH      = 256,
    parameter logic [15:0] IRQ_VECTOR = 16'h1004
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  phase,
    input  logic [15:0] db_in,
    output logic [15:0] db_out,
    output logic        db_oe,
    output logic [3:0]  per_addr,
    output logic [15:0] per_wdata,
    output logic        per_we,
    output logic        per_rd_en,
    input  logic [15:0] per_rdata
);
    localparam int AW = $clog2(DEPTH);

    bus_phase_e    ph;
    win_t          win;
    logic [15:0]   addr_q;
    logic [15:0]   wdata_q;
    logic [15:0]   word;
    logic [15:0]   ram_rdata;
    logic          ram_we;

    assign ph = bus_phase_e'(phase);

    mbus_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
        .clk(clk), .rst(rst), .ph(ph), .db_in(db_in), .own_word(word),
        .addr_q(addr_q), .wdata_q(wdata_q), .win(win)
    );

    mbus_scratch #(.DW(16), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(addr_q[AW-1:0]), .wdata(wdata_q),
        .raddr(addr_q[AW-1:0]), .rdata(ram_rdata)
    );

    mbus_drive #(.IRQ_VECTOR(IRQ_VECTOR)) u_drv (
        .clk(clk), .rst(rst), .ph(ph), .win(win), .ram_rdata(ram_rdata),
        .per_rdata(per_rdata), .word(word), .dout(db_out), .oe(db_oe),
        .per_rd_en(per_rd_en), .per_we(per_we), .ram_we(ram_we)
    );

    assign per_addr  = addr_q[3:0];
    assign per_wdata = wdata_q;

    // R4
    oe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase inside {3'd0, 3'd4, 3'd5, 3'd6, 3'd7}) |-> !db_oe);

    // R8
    vector_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2) |-> (db_oe && db_out == IRQ_VECTOR));

    // R10
    pulse_phase_chk: assert property (@(posedge clk) disable iff (rst)
        per_we |-> (phase == 3'd6));

    // R5
    ram_commit_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> (ram_rdata == $past(wdata_q) || addr_q != $past(addr_q)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (addr_q == 16'h0000 && wdata_q == 16'h0000));
endmodule

// File: tb/sim_mbus_slave.sv
module sim_mbus_slave;
    localparam logic [15:0] BASE = 16'h0100;
    localparam logic [15:0] VEC  = 16'h1004;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  phase;
    logic [15:0] db_in;
    logic [15:0] db_out;
    logic        db_oe;
    logic [3:0]  per_addr;
    logic [15:0] per_wdata;
    logic        per_we;
    logic        per_rd_en;
    logic [15:0] per_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [15:0] m_addr, m_wd;
    logic [15:0] m_mem [256];
    bit          m_known [256];

    always #2 clk = ~clk;

    assign per_rdata = {12'hC3A, per_addr};

    mbus_slave #(.BASE_ADDR(BASE), .DEPTH(256), .IRQ_VECTOR(VEC)) u0 (
        .clk(clk), .rst(rst), .phase(phase), .db_in(db_in), .db_out(db_out),
        .db_oe(db_oe), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_we(per_we), .per_rd_en(per_rd_en), .per_rdata(per_rdata)
    );

    task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_win(logic [15:0] a);
        return a[15:8] == BASE[15:8];
    endfunction

    function automatic bit in_per(logic [15:0] a);
        return in_win(a) && a[7:4] == 4'hF;
    endfunction

    task automatic cyc(logic [2:0] ph, logic [15:0] d, string tag = "");
        bit          w, p, rd, eoe, ok_word;
        logic [15:0] ew;
        @(negedge clk);
        phase = ph;
        db_in = d;
        #1;
        w   = in_win(m_addr);
        p   = in_per(m_addr);
        rd  = (ph == 3'd3) || (ph == 3'd1);
        eoe = (ph == 3'd2) || (rd && w);
        ok_word = 1'b1;
        ew  = p ? {12'hC3A, m_addr[3:0]} : m_mem[m_addr[7:0]];
        if (!p && !m_known[m_addr[7:0]]) ok_word = 1'b0;
        check(db_oe == eoe, (ph == 3'd2) ? "R8 oe" : rd ? "R3 oe" : "R4 oe",
              {15'd0, db_oe}, {15'd0, eoe});
        if (ph == 3'd2)
            check(db_out == VEC, "R8 vector", db_out, VEC);
        else if (eoe && ok_word)
            check(db_out == ew, (tag != "") ? tag : p ? "R9 data" : "R3 data", db_out, ew);
        check(per_rd_en == (rd && p), "R9 rd_en", {15'd0, per_rd_en}, {15'd0, rd && p});
        check(per_we == (ph == 3'd6 && p), "R10 we", {15'd0, per_we}, {15'd0, ph == 3'd6 && p});
        if (per_we || per_rd_en)
            check(per_addr == m_addr[3:0], "R9 per_addr", {12'd0, per_addr}, {12'd0, m_addr[3:0]});
        if (per_we)
            check(per_wdata == m_wd, "R10 wdata", per_wdata, m_wd);
        case (ph)
            3'd4, 3'd7: m_addr = d;
            3'd1:       m_addr = w ? ew : d;
            3'd5:       m_wd = d;
            3'd6: if (w && !p) begin
                m_mem[m_addr[7:0]]   = m_wd;
                m_known[m_addr[7:0]] = 1'b1;
            end
            default: ;
        endcase
        @(posedge clk);
    endtask

    task automatic wr(logic [15:0] a, logic [15:0] v);
        cyc(3'd4, a);
        cyc(3'd5, v);
        cyc(3'd6, v);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_addr = 16'h0000;
        m_wd   = 16'h0000;
        foreach (m_known[i]) m_known[i] = 1'b0;
        rst = 1'b1; phase = 3'd0; db_in = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset outputs
        check(!db_oe && !per_we, "R1 reset", {14'd0, db_oe, per_we}, 16'd0);
        check(per_addr == 4'd0 && per_wdata == 16'd0, "R1 reset", per_wdata, 16'd0);

        // R2 / R5 write then read back
        wr(16'h0105, 16'hBEEF);
        wr(16'h0110, 16'h0130);
        wr(16'h0130, 16'h5A5A);
        cyc(3'd4, 16'h0105); cyc(3'd3, 16'hFFFF, "R2 R5 readback");
        // R3 out of window
        cyc(3'd4, 16'h0205); cyc(3'd3, 16'h1111);
        // R4 quiet phases
        cyc(3'd0, 16'hABCD); cyc(3'd5, 16'h2222); cyc(3'd0, 16'h3333);
        // R6 selected next-address chain
        cyc(3'd4, 16'h0110); cyc(3'd1, 16'h7777, "R6 own word");
        cyc(3'd3, 16'h0000, "R6 chained read");
        // R6 unselected
        cyc(3'd4, 16'h4000); cyc(3'd1, 16'h0105); cyc(3'd3, 16'h0, "R6 bus word latched");
        // R7 push after acknowledge
        cyc(3'd7, 16'h0140); cyc(3'd5, 16'h1234); cyc(3'd6, 16'h1234);
        cyc(3'd4, 16'h0140); cyc(3'd3, 16'h0, "R7 push landed");
        // R8 vector
        cyc(3'd2, 16'h0);
        // R9 / R10 peripheral window
        wr(16'h01F3, 16'h9999);
        cyc(3'd3, 16'h0); cyc(3'd4, 16'h01FF); cyc(3'd3, 16'h0);
        wr(16'h01FF, 16'h8888);
        cyc(3'd4, 16'h01EF); cyc(3'd3, 16'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  ph;
            logic [15:0] d;
            ph = 3'($urandom % 8);
            d  = ($urandom % 2) ? {8'h01, 8'($urandom)} : 16'($urandom);
            if (ph == 3'd1 && in_win(m_addr) && !in_per(m_addr) && !m_known[m_addr[7:0]])
                ph = 3'd4;
            cyc(ph, d);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule